// File: doc/BRIEF.md
# Prescaled One-Shot / Periodic Timer

This block is a single timer channel: a 16-bit counter driven through an 8-bit clock prescaler. The counter runs down toward zero or up toward a programmed interval value. It either stops after its first time-out (one-shot) or reloads and keeps running (periodic). On each time-out and on each match against a programmed compare value, it emits a one-cycle pulse. Control logic elsewhere in the chip drives the configuration levels and the write strobes.

The interval value, the prescale ratio, the compare value and the prescale compare value are each written into a shadow register. A per-group select decides when a written value takes over. It can be the next clock, or it can be held back until the next time-out so that a running period is never cut short. The channel can also hold after being enabled until a trigger arrives from the preceding timer in a chain. It can be told to freeze while a debugger holds the processor halted.

Top module: `pscl_timer`

## Requirements
- R1: After reset the count reads 0xFFFF, the prescaler reads 0, the timer is stopped and both pulses are low. The interval value is 0xFFFF and the compare value is 0xFFFF, so an enable without any write starts a down-count at 0xFFFF.
- R2: With prescale value P, the prescaler runs down from P to 0 and the counter takes one step on each cycle where the prescaler is 0, so the counter steps once every P+1 active cycles (P=0 divides by 1, P=255 divides by 256).
- R3: When counting down (`count_up`=0), a time-out happens on the step taken while the count is 0, and the count reloads the interval value L. The period is (L+1)*(P+1) cycles.
- R4: When counting up (`count_up`=1), the count starts from 0. A time-out happens on the step taken while the count equals L, and the count returns to 0.
- R5: With `periodic`=0 the timer stops (`run_o` low) on its first time-out. With `periodic`=1 it keeps running.
- R6: A written interval or prescale value with `load_at_to`=0 takes effect on the clock after the write, and it restarts the count and the prescaler. With `load_at_to`=1 it takes effect only at the next time-out, and the current period runs out unchanged.
- R7: A written compare or prescale-compare value takes effect on the clock after the write while the timer runs with `match_at_to`=0, and at the next time-out when `match_at_to`=1. While the timer is stopped, the value waits and takes effect on the enabling write.
- R8: `match_o` is high for the cycle after a counting cycle in which the count equals the compare value and the prescaler equals the prescale-compare value. It stays low whenever `match_en`=0.
- R9: `timeout_o` is high for the cycle after each time-out, unless `to_int_dis`=1. In that case it stays low, although the counter still reloads.
- R10: With `stall_en`=1, the count and the prescaler hold while `dbg_halt` is high. With `stall_en`=0, `dbg_halt` has no effect.
- R11: With `wait_trig`=1, an enabled timer holds its start value until `trig_in` is seen high, and it starts counting on the following clock.
- R12: A write of 1 through `en_wr`/`en_data` sets `run_o` and restarts the count (at L when counting down, at 0 when counting up) and the prescaler (at P). A write of 0 stops the timer and leaves the count as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_up | input | 1 | 1 counts up, 0 counts down |
| periodic | input | 1 | 1 periodic, 0 one-shot |
| stall_en | input | 1 | Freeze while `dbg_halt` is high |
| dbg_halt | input | 1 | Debugger holds the processor |
| wait_trig | input | 1 | Hold after enable until a chain trigger |
| trig_in | input | 1 | Trigger from the preceding timer |
| load_at_to | input | 1 | Interval/prescale writes apply at time-out (1) or next clock (0) |
| match_at_to | input | 1 | Compare writes apply at time-out (1) or next clock (0) |
| match_en | input | 1 | Allow match pulses |
| to_int_dis | input | 1 | Suppress time-out pulses |
| en_wr | input | 1 | Enable write strobe |
| en_data | input | 1 | Enable value written |
| load_wr | input | 1 | Interval write strobe |
| load_data | input | 16 | Interval value |
| pre_wr | input | 1 | Prescale write strobe |
| pre_data | input | 8 | Prescale value |
| match_wr | input | 1 | Compare write strobe |
| match_data | input | 16 | Compare value |
| pmatch_wr | input | 1 | Prescale-compare write strobe |
| pmatch_data | input | 8 | Prescale-compare value |
| count_o | output | 16 | Current count |
| pre_o | output | 8 | Current prescaler value |
| run_o | output | 1 | Timer enabled |
| timeout_o | output | 1 | Time-out pulse |
| match_o | output | 1 | Match pulse |

## Verification
On every cycle, properties check four kinds of behaviour. The count and prescaler must hold while stalled or waiting for a trigger. A one-shot time-out must stop the timer. An up-count restart must land at 0. Deferred interval and compare values must not move before a time-out or enable. Further properties check that neither pulse appears while its gating input was set. Exact periods under several prescale ratios, the reload value after a deferred write, and the count value at which a match pulse appears can only be shown by the directed scenarios. The same holds for the reset interval and the release of a waiting timer by a trigger.

// File: rtl/pst_pkg.sv
package pst_pkg;

    // When a shadowed value is handed to the active copy
    typedef enum logic {
        UPD_NEXT_CLK   = 1'b0,
        UPD_AT_TIMEOUT = 1'b1
    } upd_sel_e;

    // Static configuration levels seen by the counting core
    typedef struct packed {
        logic count_up;
        logic periodic;
        logic stall_en;
        logic wait_trig;
        logic match_en;
        logic to_int_dis;
    } pst_cfg_t;

endpackage

// File: rtl/pst_shadow_bank.sv
module pst_shadow_bank
    import pst_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  upd_sel_e         load_sel,
    input  upd_sel_e         match_sel,
    input  logic             run,
    input  logic             en_start,
    input  logic             to_evt,
    input  logic             ld_wr,
    input  logic [CNT_W-1:0] ld_data,
    input  logic             pr_wr,
    input  logic [PRE_W-1:0] pr_data,
    input  logic             m_wr,
    input  logic [CNT_W-1:0] m_data,
    input  logic             pm_wr,
    input  logic [PRE_W-1:0] pm_data,
    output logic [CNT_W-1:0] ld_act,
    output logic [CNT_W-1:0] ld_nxt,
    output logic [PRE_W-1:0] pr_nxt,
    output logic [CNT_W-1:0] m_act,
    output logic [PRE_W-1:0] pm_act,
    output logic             ld_restart
);
    localparam logic [CNT_W-1:0] CNT_ONES = '1;

    logic [CNT_W-1:0] ld_shd, m_shd;
    logic [PRE_W-1:0] pr_shd, pr_act, pm_shd;
    logic             ld_pend, pr_pend, m_pend, pm_pend;
    logic             ld_apply, m_apply;

    assign ld_apply   = (load_sel == UPD_NEXT_CLK) || to_evt;
    assign m_apply    = en_start || (run && (match_sel == UPD_NEXT_CLK)) || to_evt;
    assign ld_nxt     = (ld_pend && ld_apply) ? ld_shd : ld_act;
    assign pr_nxt     = (pr_pend && ld_apply) ? pr_shd : pr_act;
    assign ld_restart = (load_sel == UPD_NEXT_CLK) && (ld_pend || pr_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_shd <= CNT_ONES; ld_act <= CNT_ONES; ld_pend <= 1'b0;
            pr_shd <= '0;       pr_act <= '0;       pr_pend <= 1'b0;
            m_shd  <= CNT_ONES; m_act  <= CNT_ONES; m_pend  <= 1'b0;
            pm_shd <= '0;       pm_act <= '0;       pm_pend <= 1'b0;
        end else begin
            ld_act <= ld_nxt;
            pr_act <= pr_nxt;
            if (ld_pend && ld_apply) ld_pend <= 1'b0;
            if (pr_pend && ld_apply) pr_pend <= 1'b0;
            if (m_pend && m_apply) begin
                m_act  <= m_shd;
                m_pend <= 1'b0;
            end
            if (pm_pend && m_apply) begin
                pm_act  <= pm_shd;
                pm_pend <= 1'b0;
            end
            if (ld_wr) begin ld_shd <= ld_data; ld_pend <= 1'b1; end
            if (pr_wr) begin pr_shd <= pr_data; pr_pend <= 1'b1; end
            if (m_wr)  begin m_shd  <= m_data;  m_pend  <= 1'b1; end
            if (pm_wr) begin pm_shd <= pm_data; pm_pend <= 1'b1; end
        end
    end

    AST_LOAD_DEFER: assert property (@(posedge clk) disable iff (rst)
        (ld_pend && load_sel == UPD_AT_TIMEOUT && !to_evt) |=> $stable(ld_act)); // R6
    AST_MATCH_DEFER: assert property (@(posedge clk) disable iff (rst)
        (m_pend && match_sel == UPD_AT_TIMEOUT && !en_start && !to_evt) |=> $stable(m_act)); // R7

endmodule

// File: rtl/pst_core.sv
module pst_core
    import pst_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pst_cfg_t         cfg,
    input  logic             dbg_halt,
    input  logic             trig_in,
    input  logic             en_wr,
    input  logic             en_data,
    input  logic             ld_restart,
    input  logic [CNT_W-1:0] ld_act,
    input  logic [CNT_W-1:0] ld_nxt,
    input  logic [PRE_W-1:0] pr_nxt,
    input  logic [CNT_W-1:0] m_act,
    input  logic [PRE_W-1:0] pm_act,
    output logic [CNT_W-1:0] cnt_o,
    output logic [PRE_W-1:0] pre_o,
    output logic             run_o,
    output logic             to_evt_o,
    output logic             timeout_o,
    output logic             match_o
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONES = '1;

    logic             waiting, frozen, active, step, restart, en_start;
    logic [CNT_W-1:0] limit, start_val;

    assign en_start  = en_wr && en_data;
    assign restart   = en_start || ld_restart;
    assign frozen    = cfg.stall_en && dbg_halt;
    assign active    = run_o && !waiting && !frozen;
    assign step      = active && (pre_o == '0);
    assign limit     = cfg.count_up ? ld_act : '0;
    assign to_evt_o  = step && (cnt_o == limit);
    assign start_val = cfg.count_up ? '0 : ld_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o     <= CNT_ONES;
            pre_o     <= '0;
            run_o     <= 1'b0;
            waiting   <= 1'b0;
            timeout_o <= 1'b0;
            match_o   <= 1'b0;
        end else begin
            timeout_o <= to_evt_o && !cfg.to_int_dis;
            match_o   <= active && cfg.match_en && (cnt_o == m_act) && (pre_o == pm_act);

            if (restart) begin
                cnt_o <= start_val;
                pre_o <= pr_nxt;
            end else if (active) begin
                if (pre_o != '0) begin
                    pre_o <= pre_o - PRE_ONE;
                end else begin
                    pre_o <= pr_nxt;
                    if (to_evt_o)          cnt_o <= start_val;
                    else if (cfg.count_up) cnt_o <= cnt_o + CNT_ONE;
                    else                   cnt_o <= cnt_o - CNT_ONE;
                end
            end

            if (en_wr)                            run_o <= en_data;
            else if (to_evt_o && !cfg.periodic)   run_o <= 1'b0;

            if (en_start)     waiting <= cfg.wait_trig;
            else if (trig_in) waiting <= 1'b0;
        end
    end

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (run_o && frozen && !restart) |=> ($stable(cnt_o) && $stable(pre_o))); // R10
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_o && waiting && !restart) |=> $stable(cnt_o)); // R11
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (to_evt_o && !cfg.periodic && !en_wr) |=> !run_o); // R5
    AST_UP_START: assert property (@(posedge clk) disable iff (rst)
        (restart && cfg.count_up) |=> (cnt_o == '0)); // R4

endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
    import pst_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_up,
    input  logic             periodic,
    input  logic             stall_en,
    input  logic             dbg_halt,
    input  logic             wait_trig,
    input  logic             trig_in,
    input  logic             load_at_to,
    input  logic             match_at_to,
    input  logic             match_en,
    input  logic             to_int_dis,
    input  logic             en_wr,
    input  logic             en_data,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_data,
    input  logic             pre_wr,
    input  logic [PRE_W-1:0] pre_data,
    input  logic             match_wr,
    input  logic [CNT_W-1:0] match_data,
    input  logic             pmatch_wr,
    input  logic [PRE_W-1:0] pmatch_data,
    output logic [CNT_W-1:0] count_o,
    output logic [PRE_W-1:0] pre_o,
    output logic             run_o,
    output logic             timeout_o,
    output logic             match_o
);
    pst_cfg_t         cfg;
    logic [CNT_W-1:0] ld_act, ld_nxt, m_act;
    logic [PRE_W-1:0] pr_nxt, pm_act;
    logic             ld_restart, to_evt;

    assign cfg = '{count_up: count_up, periodic: periodic, stall_en: stall_en,
                   wait_trig: wait_trig, match_en: match_en, to_int_dis: to_int_dis};

    pst_shadow_bank #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_bank (
        .clk(clk), .rst(rst),
        .load_sel(upd_sel_e'(load_at_to)), .match_sel(upd_sel_e'(match_at_to)),
        .run(run_o), .en_start(en_wr && en_data), .to_evt(to_evt),
        .ld_wr(load_wr), .ld_data(load_data), .pr_wr(pre_wr), .pr_data(pre_data),
        .m_wr(match_wr), .m_data(match_data), .pm_wr(pmatch_wr), .pm_data(pmatch_data),
        .ld_act(ld_act), .ld_nxt(ld_nxt), .pr_nxt(pr_nxt), .m_act(m_act),
        .pm_act(pm_act), .ld_restart(ld_restart)
    );

    pst_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
        .clk(clk), .rst(rst), .cfg(cfg), .dbg_halt(dbg_halt), .trig_in(trig_in),
        .en_wr(en_wr), .en_data(en_data), .ld_restart(ld_restart),
        .ld_act(ld_act), .ld_nxt(ld_nxt), .pr_nxt(pr_nxt), .m_act(m_act), .pm_act(pm_act),
        .cnt_o(count_o), .pre_o(pre_o), .run_o(run_o), .to_evt_o(to_evt),
        .timeout_o(timeout_o), .match_o(match_o)
    );

    AST_TO_GATED: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> !$past(to_int_dis)); // R9
    AST_MATCH_GATED: assert property (@(posedge clk) disable iff (rst)
        match_o |-> $past(match_en)); // R8

endmodule

// File: tb/sim_pscl_timer.sv
module sim_pscl_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        count_up = 0, periodic = 1, stall_en = 0, dbg_halt = 0;
    logic        wait_trig = 0, trig_in = 0, load_at_to = 0, match_at_to = 0;
    logic        match_en = 0, to_int_dis = 0, en_wr = 0, en_data = 0;
    logic        load_wr = 0, pre_wr = 0, match_wr = 0, pmatch_wr = 0;
    logic [15:0] load_data = '0, match_data = '0;
    logic [7:0]  pre_data = '0, pmatch_data = '0;
    logic [15:0] count_o;
    logic [7:0]  pre_o;
    logic        run_o, timeout_o, match_o;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    pscl_timer u0 (.*);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_load(input logic [15:0] v);
        load_wr = 1; load_data = v; cyc(1); load_wr = 0;
    endtask

    task automatic wr_pre(input logic [7:0] v);
        pre_wr = 1; pre_data = v; cyc(1); pre_wr = 0;
    endtask

    task automatic wr_match(input logic [15:0] v);
        match_wr = 1; match_data = v; cyc(1); match_wr = 0;
    endtask

    task automatic set_en(input logic v);
        en_wr = 1; en_data = v; cyc(1); en_wr = 0;
    endtask

    task automatic t_reset;
        chk("R1", "count", count_o, 16'hFFFF);
        chk("R1", "prescaler", pre_o, 0);
        chk("R1", "run", run_o, 0);
        chk("R1", "pulses", {timeout_o, match_o}, 0);
        set_en(1);
        chk("R1", "default start", count_o, 16'hFFFF);
        cyc(1);
        chk("R3", "first down step", count_o, 16'hFFFE);
        set_en(0);
    endtask

    task automatic t_down_periodic;
        int pulses = 0;
        wr_load(3); cyc(1);
        set_en(1);
        chk("R12", "start at load", count_o, 3);
        cyc(3);
        chk("R3", "reached zero", count_o, 0);
        cyc(1);
        chk("R3", "reload after zero", count_o, 3);
        chk("R9", "time-out pulse", timeout_o, 1);
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            if (timeout_o) pulses++;
        end
        chk("R5", "periodic pulses in 8 cycles", pulses, 2);
        chk("R5", "still running", run_o, 1);
        set_en(0);
    endtask

    task automatic t_prescale;
        wr_load(2); wr_pre(2); cyc(1);
        set_en(1);
        chk("R12", "prescaler restart", pre_o, 2);
        cyc(3);
        chk("R2", "one step after 3 cycles", count_o, 1);
        chk("R2", "prescaler reloaded", pre_o, 2);
        cyc(5);
        chk("R3", "no time-out before period end", timeout_o, 0);
        cyc(1);
        chk("R3", "time-out at 9 cycles", timeout_o, 1);
        chk("R3", "reloaded count", count_o, 2);
        set_en(0);
        wr_pre(0); cyc(1);
    endtask

    task automatic t_up_oneshot;
        count_up = 1; periodic = 0;
        wr_load(2); cyc(1);
        set_en(1);
        chk("R4", "up starts at 0", count_o, 0);
        cyc(2);
        chk("R4", "reached limit", count_o, 2);
        cyc(1);
        chk("R4", "back to 0", count_o, 0);
        chk("R4", "time-out at limit", timeout_o, 1);
        chk("R5", "one-shot stopped", run_o, 0);
        cyc(1);
        chk("R5", "count holds after stop", count_o, 0);
        chk("R9", "single pulse", timeout_o, 0);
        count_up = 0; periodic = 1;
    endtask

    task automatic t_defer_load;
        wr_load(3); cyc(1);
        set_en(1);
        load_at_to = 1;
        wr_load(1);
        chk("R6", "deferred write does not restart", count_o, 2);
        cyc(2);
        chk("R6", "old period runs out", count_o, 0);
        cyc(1);
        chk("R6", "new load at time-out", count_o, 1);
        cyc(2);
        chk("R6", "new period length", count_o, 1);
        chk("R6", "second time-out", timeout_o, 1);
        set_en(0);
        load_at_to = 0;
    endtask

    task automatic t_match_now;
        int pulses = 0;
        wr_load(5); cyc(1);
        match_en = 1;
        set_en(1);
        wr_match(2); cyc(1);
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (match_o) begin
                pulses++;
                chk("R8", "count after match", count_o, 1);
            end
        end
        chk("R7", "immediate match pulses", pulses, 2);
        match_en = 0;
        pulses = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (match_o) pulses++;
        end
        chk("R8", "pulses with match disabled", pulses, 0);
        set_en(0);
    endtask

    task automatic t_match_idle;
        int pulses = 0;
        match_at_to = 1; match_en = 1;
        wr_match(4); cyc(2);
        set_en(1);
        for (int i = 0; i < 6; i++) begin
            cyc(1);
            if (match_o) begin
                pulses++;
                chk("R7", "match value applied at enable", count_o, 3);
            end
        end
        chk("R7", "pulses after enable", pulses, 1);
        set_en(0);
        match_at_to = 0; match_en = 0;
    endtask

    task automatic t_stall;
        set_en(1);
        stall_en = 1; dbg_halt = 1;
        cyc(3);
        chk("R10", "frozen while halted", count_o, 5);
        dbg_halt = 0; cyc(1);
        chk("R10", "resumes", count_o, 4);
        stall_en = 0; dbg_halt = 1; cyc(1);
        chk("R10", "halt ignored without stall", count_o, 3);
        dbg_halt = 0;
        set_en(0);
    endtask

    task automatic t_wait;
        wait_trig = 1;
        set_en(1);
        cyc(3);
        chk("R11", "holds before trigger", count_o, 5);
        trig_in = 1; cyc(1); trig_in = 0;
        chk("R11", "trigger edge itself", count_o, 5);
        cyc(1);
        chk("R11", "counts after trigger", count_o, 4);
        wait_trig = 0;
        set_en(0);
    endtask

    task automatic t_to_masked;
        int pulses = 0;
        to_int_dis = 1;
        wr_load(1); cyc(1);
        set_en(1);
        cyc(2);
        chk("R9", "reload while masked", count_o, 1);
        for (int i = 0; i < 6; i++) begin
            if (timeout_o) pulses++;
            cyc(1);
        end
        chk("R9", "masked pulses", pulses, 0);
        to_int_dis = 0;
        set_en(0);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        t_reset();
        t_down_periodic();
        t_prescale();
        t_up_oneshot();
        t_defer_load();
        t_match_now();
        t_match_idle();
        t_stall();
        t_wait();
        t_to_masked();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule